// File: doc/BRIEF.md
# Rectangular Region Address Generator

This block walks a rectangular pixel area stored in byte-addressed memory and produces one byte address per accepted pixel request. A single start pulse latches a base address, a width in pixels, a line count, a pixel size, a gap in pixels that is skipped after every line, and a chosen marker line. The block then offers addresses in raster order: left to right along a line, then line after line. A consumer takes each address with a handshake.

Pixel sizes of 32, 24, 16, 8 and 4 bits are supported. With 4-bit pixels, two pixels share a byte, and a half-select output says which nibble is meant. The request is checked when start is seen. A misaligned base, or an odd width or gap with 4-bit pixels, is refused with an error pulse, and no address is then produced. An empty area (zero width or zero lines) finishes at once. A one-cycle marker pulse follows the take of the last pixel of the chosen line, and a done pulse follows the take of the final pixel.

Top module: `rect_addr_gen`

## Requirements
- R1: After reset, pix_valid, done, cfg_err and mark_pulse are all 0.
- R2: A start accepted while idle with a legal, non-empty request latches the configuration. pix_valid rises one cycle later, and the first address equals the base with pix_first = 1. pix_first is 0 for every other pixel.
- R3: The pixel size code cfg_fmt is 0 = 32-bit (4 bytes), 1 = 24-bit (3 bytes), 2 = 16-bit (2 bytes), 3 = 8-bit (1 byte), 4 = 4-bit. For a pixel at linear position p, the address is base + p × bytes. While pix_valid is high and pix_take is low, the address holds.
- R4: The linear position of line r, column c is r × (width + gap) + c. The gap is counted in pixels and is added once at the end of each line.
- R5: With 4-bit pixels, the address is base + floor(p / 2), and pix_nib = p mod 2 (1 = upper half). For all other sizes, pix_nib is 0.
- R6: pix_last is high only on the final pixel of the area. One cycle after it is taken, done pulses for one cycle and pix_valid falls.
- R7: mark_pulse is high for one cycle in the cycle after the take of the last pixel of line cfg_mark, where lines are counted from 0. If cfg_mark is not below the line count, mark_pulse never fires.
- R8: The base must be a multiple of 4 for fmt 0 and a multiple of 2 for fmt 2. Fmt 1 and 3 accept any base. For fmt 4, the width and the gap must both be even. Codes 5 to 7 are illegal. A violation gives a one-cycle cfg_err pulse in the cycle after start, with no address and no done.
- R9: A legal start with zero width or zero lines gives a done pulse in the cycle after start and issues no address.
- R10: A start while busy is ignored. Input configuration changes while busy do not alter the sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new region walk |
| cfg_base | input | ADDR_W | Byte address of the first pixel |
| cfg_skip | input | OFFS_W | Pixels skipped after each line |
| cfg_width | input | PIX_W | Pixels per line |
| cfg_lines | input | LINES_W | Number of lines |
| cfg_fmt | input | 3 | Pixel size code |
| cfg_mark | input | LINES_W | Zero-based marker line |
| pix_take | input | 1 | Consumer takes the current address |
| pix_valid | output | 1 | An address is offered |
| pix_addr | output | ADDR_W | Current byte address |
| pix_nib | output | 1 | Upper-nibble select for 4-bit pixels |
| pix_first | output | 1 | Current pixel is the first of the area |
| pix_last | output | 1 | Current pixel is the last of the area |
| mark_pulse | output | 1 | Marker line has been completed |
| cfg_err | output | 1 | Start refused for an illegal request |
| done | output | 1 | Region finished |

## Verification
The marker pulse and the done pulse fall in the same cycle when the marker line is the final line of the area. When the line width is 1, the marker pulse can also land in the cycle right after an ordinary line change. The sweep provokes these cases by setting the marker to every line index, and to indices past the last line, for every size, width, line count and gap. At the edge after each take, it checks mark_pulse and done together against expectations derived from the pixel count. A refused start and an empty start are also driven across all size codes, to confirm that the error pulse and the done pulse never appear together.

// File: rtl/rag_pkg.sv
package rag_pkg;
  typedef enum logic [2:0] {
    PX32 = 3'd0,
    PX24 = 3'd1,
    PX16 = 3'd2,
    PX8  = 3'd3,
    PX4  = 3'd4
  } pix_fmt_e;

  function automatic logic fmt_known(logic [2:0] code);
    return code <= 3'd4;
  endfunction
endpackage

// File: rtl/rag_cfg_check.sv
module rag_cfg_check
  import rag_pkg::*;
(
  input  logic [2:0] fmt,
  input  logic [1:0] base_lo,
  input  logic       width_odd,
  input  logic       skip_odd,
  output logic       bad
);
  always_comb begin
    bad = 1'b0;
    if (!fmt_known(fmt)) begin
      bad = 1'b1;
    end else begin
      case (pix_fmt_e'(fmt))
        PX32:    bad = (base_lo != 2'b00);
        PX16:    bad = base_lo[0];
        PX4:     bad = width_odd | skip_odd;
        default: bad = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rag_scan_ctr.sv
module rag_scan_ctr #(
  parameter int PIX_W   = 14,
  parameter int LINES_W = 16,
  parameter int OFFS_W  = 16,
  parameter int LIN_W   = 33
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               step,
  input  logic [PIX_W-1:0]   width,
  input  logic [LINES_W-1:0] lines,
  input  logic [OFFS_W-1:0]  skip,
  output logic [PIX_W-1:0]   col,
  output logic [LINES_W-1:0] row,
  output logic [LIN_W-1:0]   lin,
  output logic               line_end,
  output logic               frame_end
);
  assign line_end  = (col == width - PIX_W'(1));
  assign frame_end = line_end && (row == lines - LINES_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col <= '0;
      row <= '0;
      lin <= '0;
    end else if (clear) begin
      col <= '0;
      row <= '0;
      lin <= '0;
    end else if (step) begin
      if (line_end) begin
        col <= '0;
        row <= row + LINES_W'(1);
        lin <= lin + LIN_W'(skip) + LIN_W'(1);
      end else begin
        col <= col + PIX_W'(1);
        lin <= lin + LIN_W'(1);
      end
    end
  end
endmodule

// File: rtl/rag_addr_map.sv
module rag_addr_map
  import rag_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIN_W  = 33
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LIN_W-1:0]  lin,
  input  pix_fmt_e          fmt,
  output logic [ADDR_W-1:0] addr,
  output logic              nib
);
  localparam int OFF_W = LIN_W + 2;

  function automatic logic [OFF_W-1:0] byte_off(pix_fmt_e f, logic [LIN_W-1:0] p);
    logic [OFF_W-1:0] e;
    e = {2'b00, p};
    case (f)
      PX32:    return e << 2;
      PX24:    return (e << 1) + e;
      PX16:    return e << 1;
      PX8:     return e;
      default: return e >> 1;
    endcase
  endfunction

  logic [OFF_W-1:0] off_w;
  assign off_w = byte_off(fmt, lin);
  assign addr  = base + ADDR_W'(off_w);
  assign nib   = (fmt == PX4) && lin[0];
endmodule

// File: rtl/rect_addr_gen.sv
module rect_addr_gen
  import rag_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int PIX_W   = 14,
  parameter int LINES_W = 16,
  parameter int OFFS_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [OFFS_W-1:0]  cfg_skip,
  input  logic [PIX_W-1:0]   cfg_width,
  input  logic [LINES_W-1:0] cfg_lines,
  input  logic [2:0]         cfg_fmt,
  input  logic [LINES_W-1:0] cfg_mark,
  input  logic               pix_take,
  output logic               pix_valid,
  output logic [ADDR_W-1:0]  pix_addr,
  output logic               pix_nib,
  output logic               pix_first,
  output logic               pix_last,
  output logic               mark_pulse,
  output logic               cfg_err,
  output logic               done
);
  localparam int SPAN_W = (OFFS_W > PIX_W) ? OFFS_W : PIX_W;
  localparam int LIN_W  = LINES_W + SPAN_W + 1;

  logic               busy_q;
  logic [ADDR_W-1:0]  base_q;
  logic [OFFS_W-1:0]  skip_q;
  logic [PIX_W-1:0]   width_q;
  logic [LINES_W-1:0] lines_q;
  logic [LINES_W-1:0] mark_q;
  pix_fmt_e           fmt_q;

  logic               start_acc_w;
  logic               bad_cfg_w;
  logic               empty_w;
  logic               launch_w;
  logic               take_w;
  logic               line_end_w;
  logic               frame_end_w;
  logic               fin_w;
  logic               mark_hit_w;
  logic [PIX_W-1:0]   col_w;
  logic [LINES_W-1:0] row_w;
  logic [LIN_W-1:0]   lin_w;

  rag_cfg_check u_check (
    .fmt       (cfg_fmt),
    .base_lo   (cfg_base[1:0]),
    .width_odd (cfg_width[0]),
    .skip_odd  (cfg_skip[0]),
    .bad       (bad_cfg_w)
  );

  assign start_acc_w = start && !busy_q;
  assign empty_w     = (cfg_width == '0) || (cfg_lines == '0);
  assign launch_w    = start_acc_w && !bad_cfg_w && !empty_w;
  assign take_w      = busy_q && pix_take;
  assign fin_w       = take_w && frame_end_w;
  assign mark_hit_w  = take_w && line_end_w && (row_w == mark_q);

  rag_scan_ctr #(
    .PIX_W   (PIX_W),
    .LINES_W (LINES_W),
    .OFFS_W  (OFFS_W),
    .LIN_W   (LIN_W)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (launch_w),
    .step      (take_w),
    .width     (width_q),
    .lines     (lines_q),
    .skip      (skip_q),
    .col       (col_w),
    .row       (row_w),
    .lin       (lin_w),
    .line_end  (line_end_w),
    .frame_end (frame_end_w)
  );

  rag_addr_map #(
    .ADDR_W (ADDR_W),
    .LIN_W  (LIN_W)
  ) u_map (
    .base (base_q),
    .lin  (lin_w),
    .fmt  (fmt_q),
    .addr (pix_addr),
    .nib  (pix_nib)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      base_q     <= '0;
      skip_q     <= '0;
      width_q    <= '0;
      lines_q    <= '0;
      mark_q     <= '0;
      fmt_q      <= PX32;
      cfg_err    <= 1'b0;
      done       <= 1'b0;
      mark_pulse <= 1'b0;
    end else begin
      if (launch_w) begin
        busy_q  <= 1'b1;
        base_q  <= cfg_base;
        skip_q  <= cfg_skip;
        width_q <= cfg_width;
        lines_q <= cfg_lines;
        mark_q  <= cfg_mark;
        fmt_q   <= pix_fmt_e'(cfg_fmt);
      end else if (fin_w) begin
        busy_q <= 1'b0;
      end
      cfg_err    <= start_acc_w && bad_cfg_w;
      done       <= fin_w || (start_acc_w && !bad_cfg_w && empty_w);
      mark_pulse <= mark_hit_w;
    end
  end

  assign pix_valid = busy_q;
  assign pix_first = busy_q && (col_w == '0) && (row_w == '0);
  assign pix_last  = busy_q && frame_end_w;
endmodule

// File: rtl/rag_chk.sv
module rag_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              pix_take,
  input logic              pix_valid,
  input logic [ADDR_W-1:0] pix_addr,
  input logic              pix_nib,
  input logic              pix_first,
  input logic              pix_last,
  input logic              mark_pulse,
  input logic              cfg_err,
  input logic              done,
  input logic [2:0]        fmt_q,
  input logic              line_end
);
  p_first_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pix_valid) |-> pix_first && !pix_nib);

  p_hold_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_take |=> pix_valid && $stable(pix_addr));

  p_byte_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_take && !line_end && fmt_q == 3'd3 |=> pix_addr == $past(pix_addr) + ADDR_W'(1));

  p_nib_wide_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && fmt_q != 3'd4 |-> !pix_nib);

  p_done_after_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_take && pix_last |=> done && !pix_valid);

  p_mark_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mark_pulse |=> !mark_pulse);

  p_err_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !pix_valid && !done);

  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && start |=> !cfg_err);
endmodule

bind rect_addr_gen rag_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .pix_take   (pix_take),
  .pix_valid  (pix_valid),
  .pix_addr   (pix_addr),
  .pix_nib    (pix_nib),
  .pix_first  (pix_first),
  .pix_last   (pix_last),
  .mark_pulse (mark_pulse),
  .cfg_err    (cfg_err),
  .done       (done),
  .fmt_q      (fmt_q),
  .line_end   (line_end_w)
);

// File: tb/rect_addr_gen_tb.sv
`timescale 1ns/1ps
module rect_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_skip = '0;
  logic [13:0] cfg_width = '0;
  logic [15:0] cfg_lines = '0;
  logic [2:0]  cfg_fmt = '0;
  logic [15:0] cfg_mark = '0;
  logic        pix_take = 1'b0;
  logic        pix_valid, pix_nib, pix_first, pix_last, mark_pulse, cfg_err, done;
  logic [31:0] pix_addr;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  rect_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_base(cfg_base),
    .cfg_skip(cfg_skip), .cfg_width(cfg_width), .cfg_lines(cfg_lines),
    .cfg_fmt(cfg_fmt), .cfg_mark(cfg_mark), .pix_take(pix_take),
    .pix_valid(pix_valid), .pix_addr(pix_addr), .pix_nib(pix_nib),
    .pix_first(pix_first), .pix_last(pix_last), .mark_pulse(mark_pulse),
    .cfg_err(cfg_err), .done(done)
  );

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit ref_bad(int f, int b, int w, int s);
    if (f == 0) return (b % 4) != 0;
    if (f == 2) return (b % 2) != 0;
    if (f == 1 || f == 3) return 1'b0;
    if (f == 4) return ((w % 2) != 0) || ((s % 2) != 0);
    return 1'b1;
  endfunction

  function automatic int ref_bytes(int f);
    return (f == 0) ? 4 : (f == 1) ? 3 : (f == 2) ? 2 : 1;
  endfunction

  task automatic run_region(int f, int b, int w, int h, int s, int m, int seed, bit poke);
    bit exp_bad, exp_empty, pend_mark, tk;
    int issued, k, r, c, p;
    logic [31:0] exp_addr;
    string tg;
    exp_bad   = ref_bad(f, b, w, s);
    exp_empty = (w == 0) || (h == 0);
    @(negedge clk);
    cfg_fmt = 3'(f); cfg_base = 32'(b); cfg_width = 14'(w);
    cfg_lines = 16'(h); cfg_skip = 16'(s); cfg_mark = 16'(m);
    start = 1'b1; pix_take = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (exp_bad) begin
      chk("R8", "cfg_err", 64'(cfg_err), 64'd1);
      chk("R8", "valid on error", 64'(pix_valid), 64'd0);
      chk("R8", "done on error", 64'(done), 64'd0);
      @(negedge clk);
      chk("R8", "valid after error", 64'(pix_valid), 64'd0);
      chk("R8", "err pulse width", 64'(cfg_err), 64'd0);
      return;
    end
    chk("R8", "no cfg_err", 64'(cfg_err), 64'd0);
    if (exp_empty) begin
      chk("R9", "done empty", 64'(done), 64'd1);
      chk("R9", "valid empty", 64'(pix_valid), 64'd0);
      @(negedge clk);
      chk("R9", "valid after empty", 64'(pix_valid), 64'd0);
      return;
    end
    chk("R2", "valid after start", 64'(pix_valid), 64'd1);
    issued = 0; pend_mark = 1'b0; k = seed;
    while (issued < w * h) begin
      chk("R7", "mark", 64'(mark_pulse), 64'(pend_mark));
      pend_mark = 1'b0;
      if (!pix_valid) begin
        chk("R2", "valid mid-region", 64'(pix_valid), 64'd1);
        return;
      end
      r = issued / w; c = issued % w; p = r * (w + s) + c;
      if (f == 4) exp_addr = 32'(b) + 32'(p / 2);
      else        exp_addr = 32'(b) + 32'(p * ref_bytes(f));
      tg = poke ? "R10" : (c == 0 && r > 0) ? "R4" : (f == 4) ? "R5" : "R3";
      chk(tg, "addr", 64'(pix_addr), 64'(exp_addr));
      chk("R5", "nib", 64'(pix_nib), (f == 4) ? 64'(p % 2) : 64'd0);
      chk("R2", "first", 64'(pix_first), 64'(issued == 0));
      chk("R6", "last", 64'(pix_last), 64'(issued == w * h - 1));
      chk("R6", "no early done", 64'(done), 64'd0);
      tk = (k % 3) != 1; k++;
      pix_take = tk;
      if (poke && issued == 1) begin
        start = 1'b1; cfg_base = 32'h0DEA_0000; cfg_width = 14'd7; cfg_skip = 16'd5;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (tk) begin
        if (c == w - 1 && r == m) pend_mark = 1'b1;
        issued++;
      end
    end
    pix_take = 1'b0; start = 1'b0;
    chk("R6", "done", 64'(done), 64'd1);
    chk("R6", "valid after last", 64'(pix_valid), 64'd0);
    chk("R7", "mark at end", 64'(mark_pulse), 64'(pend_mark));
    if (poke) chk("R10", "no err while busy", 64'(cfg_err), 64'd0);
    @(negedge clk);
    chk("R6", "done pulse width", 64'(done), 64'd0);
    chk("R7", "mark cleared", 64'(mark_pulse), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "valid", 64'(pix_valid), 64'd0);
    chk("R1", "done", 64'(done), 64'd0);
    chk("R1", "cfg_err", 64'(cfg_err), 64'd0);
    chk("R1", "mark", 64'(mark_pulse), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after release", 64'(pix_valid), 64'd0);

    for (int f = 0; f < 5; f++)
      for (int w = 0; w < 4; w++)
        for (int h = 0; h < 4; h++)
          for (int s = 0; s < 3; s++)
            for (int m = 0; m < 4; m++)
              run_region(f, 32'h2000_0100, w, h, s, m, f + w + m, 1'b0);

    for (int f = 0; f < 8; f++)
      for (int lo = 0; lo < 4; lo++)
        for (int w = 2; w < 4; w++)
          for (int s = 1; s < 3; s++)
            run_region(f, 32'h0000_4000 + lo, w, 2, s, 1, lo, 1'b0);

    run_region(3, 32'h0000_0040, 3, 2, 1, 1, 0, 1'b1);
    run_region(4, 32'h0000_0081, 4, 2, 2, 0, 2, 1'b1);
    run_region(0, 32'h1000_0000, 0, 5, 0, 0, 0, 1'b0);
    run_region(5, 32'h1000_0000, 0, 0, 0, 0, 0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule